// File: doc/BRIEF.md
# Single-Word Handshake Buffer

The block holds one data word on its way from a sender to a receiver. Both sides use a four-phase, return-to-zero request/acknowledge handshake. The sender presents a word and raises its request. The buffer answers only when it is empty: it captures the word and raises its input acknowledge. The buffer itself lowers that acknowledge once the sender has withdrawn its request.

A captured word is driven on the output bus and announced with an output request. The buffer drops that request once the receiver acknowledges. The buffer only counts as empty again after the receiver has also lowered its acknowledge. Word acceptances and word deliveries therefore strictly alternate. Reset is asynchronous and active low. It empties the buffer, clears the stored word and lowers both handshake outputs the buffer drives.

Top module: `hs_word_buffer`

## Requirements
- R1: While and after reset, `in_ack_o` and `out_req_o` are 0 and `out_data_o` is all zeros.
- R2: If `in_req_i` is high at a rising clock edge while the buffer is empty and `in_ack_o` is low, `in_ack_o` is high after that edge and the word on `in_data_i` at that edge is captured.
- R3: While the buffer holds a word, a high `in_req_i` is not acknowledged. Every rise of `in_ack_o` follows a rise of `out_ack_i` after the previous rise of `in_ack_o` (no overflow).
- R4: `in_ack_o` falls one edge after `in_req_i` is sampled low. It never rises while `in_req_i` was low and never falls while `in_req_i` was high.
- R5: `out_req_o` rises one edge after the capture edge, with `out_data_o` equal to the captured word. `out_data_o` stays stable while `out_req_o` is high.
- R6: `out_req_o` falls one edge after `out_ack_i` is sampled high, and it never rises while `out_ack_i` was high.
- R7: After a delivery, `out_req_o` stays low until a new word is accepted. Every rise of `out_req_o` follows a rise of `in_ack_o` (no underflow).
- R8: The words delivered to the receiver are the accepted words, in acceptance order, each equal to the word captured at the latest rise of `in_ack_o`.
- R9: The buffer becomes empty only at the edge that samples `out_ack_i` low after the delivery. A waiting request is acknowledged one edge after that, never while `out_ack_i` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_req_i | input | 1 | Sender request |
| in_ack_o | output | 1 | Acknowledge to the sender |
| in_data_i | input | DATA_W | Word from the sender |
| out_req_o | output | 1 | Request to the receiver |
| out_ack_i | input | 1 | Receiver acknowledge |
| out_data_o | output | DATA_W | Word to the receiver |

## Verification
The hardest state to reach is a sender request that waits on a full buffer while the receiver still holds its acknowledge high. Only there does it show whether the buffer frees itself too early, at the acknowledge rise instead of its fall. The bench parks a second word on the input, holds the output acknowledge high for several cycles and checks that no input acknowledge appears. It then releases the acknowledge and checks the exact edge on which the waiting word is taken. A streaming phase follows with varied sender gaps and receiver delays and hold times, so that the two handshakes overlap in many relative phases.

// File: rtl/hs_buf_pkg.sv
package hs_buf_pkg;
  typedef enum logic {
    IN_IDLE,
    IN_ACKED
  } in_state_e;

  typedef enum logic [1:0] {
    OUT_IDLE,
    OUT_OFFER,
    OUT_RELEASE
  } out_state_e;
endpackage

// File: rtl/hs_in_ctrl.sv
module hs_in_ctrl
  import hs_buf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic full_i,
  output logic ack_o,
  output logic load_o
);
  in_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    unique case (state_q)
      IN_IDLE: if (req_i && !full_i) begin
        load_o  = 1'b1;
        state_d = IN_ACKED;
      end
      IN_ACKED: if (!req_i) state_d = IN_IDLE;
      default: state_d = IN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= IN_IDLE;
    else         state_q <= state_d;
  end

  assign ack_o = (state_q == IN_ACKED);

  // R4: ack follows the request level of the previous cycle
  a_r4_ack_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(req_i));
  a_r4_ack_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |-> !$past(req_i));
endmodule

// File: rtl/hs_out_ctrl.sv
module hs_out_ctrl
  import hs_buf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_i,
  input  logic ack_i,
  output logic req_o,
  output logic done_o
);
  out_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    done_o  = 1'b0;
    unique case (state_q)
      OUT_IDLE:    if (full_i && !ack_i) state_d = OUT_OFFER;
      OUT_OFFER:   if (ack_i) state_d = OUT_RELEASE;
      OUT_RELEASE: if (!ack_i) begin
        done_o  = 1'b1;
        state_d = OUT_IDLE;
      end
      default: state_d = OUT_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= OUT_IDLE;
    else         state_q <= state_d;
  end

  assign req_o = (state_q == OUT_OFFER);

  a_r6_req_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> !$past(ack_i));
  a_r6_req_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> $past(ack_i));
endmodule

// File: rtl/hs_slot.sv
module hs_slot #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (load_i) begin
      data_q <= data_i;
      full_q <= 1'b1;
    end else if (clear_i) begin
      full_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
endmodule

// File: rtl/hs_word_buffer.sv
module hs_word_buffer #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_req_i,
  output logic              in_ack_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_req_o,
  input  logic              out_ack_i,
  output logic [DATA_W-1:0] out_data_o
);
  logic load, done, full;

  hs_in_ctrl i_in_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (in_req_i),
    .full_i (full),
    .ack_o  (in_ack_o),
    .load_o (load)
  );

  hs_slot #(.DATA_W(DATA_W)) i_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .clear_i (done),
    .data_i  (in_data_i),
    .data_o  (out_data_o),
    .full_o  (full)
  );

  hs_out_ctrl i_out_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .full_i (full),
    .ack_i  (out_ack_i),
    .req_o  (out_req_o),
    .done_o (done)
  );

  // Port-level bookkeeping for the alternation and data checks
  logic              in_ack_d, out_ack_d, owe_q;
  logic [DATA_W-1:0] in_data_d, shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_ack_d  <= 1'b0;
      out_ack_d <= 1'b0;
      owe_q     <= 1'b0;
      in_data_d <= '0;
      shadow_q  <= '0;
    end else begin
      in_ack_d  <= in_ack_o;
      out_ack_d <= out_ack_i;
      in_data_d <= in_data_i;
      if (in_ack_o && !in_ack_d) begin
        owe_q    <= 1'b1;
        shadow_q <= in_data_d;
      end else if (out_ack_i && !out_ack_d) begin
        owe_q <= 1'b0;
      end
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ack_o) |-> !owe_q);
  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_req_o) |-> owe_q);
  a_r8_data_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_ack_i) |-> out_data_o == shadow_q);
  a_r5_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_req_o && $past(out_req_o)) |-> $stable(out_data_o));
endmodule

// File: tb/test_hs_word_buffer.sv
`timescale 1ns/1ps
module test_hs_word_buffer;
  localparam int unsigned W = 32;
  localparam int unsigned N_STREAM = 40;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_req = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         out_ack = 1'b0;
  logic         in_ack, out_req;
  logic [W-1:0] out_data;

  int n_checks = 0;
  int n_fail = 0;
  int delivered = 0;
  bit rx_auto = 1'b0;
  bit done_flag = 1'b0;
  logic [W-1:0] exp_q[$];

  always #4 clk = ~clk;

  hs_word_buffer #(.DATA_W(W)) i_hs_word_buffer (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .in_req_i   (in_req),
    .in_ack_o   (in_ack),
    .in_data_i  (in_data),
    .out_req_o  (out_req),
    .out_ack_i  (out_ack),
    .out_data_o (out_data)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // Sender driver: pushes the expected word into the scoreboard
  task automatic send(input logic [W-1:0] w);
    @(negedge clk);
    in_data = w;
    in_req  = 1'b1;
    exp_q.push_back(w);
    while (!in_ack) @(negedge clk);
    in_req  = 1'b0;
    in_data = ~w;
    while (in_ack) @(negedge clk);
  endtask

  // Receiver monitor: pops and compares each offered word
  initial begin
    int gap = 0;
    int hold = 1;
    forever begin
      @(negedge clk);
      if (rx_auto && out_req && !out_ack) begin
        repeat (gap) @(negedge clk);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected word", out_data, '0);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          check(out_data == e, "R8 stream order", out_data, e);
        end
        delivered++;
        out_ack = 1'b1;
        @(negedge clk);
        while (out_req) @(negedge clk);
        repeat (hold) @(negedge clk);
        out_ack = 1'b0;
        gap  = (gap + 1) % 4;
        hold = (hold + 2) % 5;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] wa, wb;
    int bad;
    wa = 32'hFFFF_FFFF;
    wb = 32'h0000_0000;

    repeat (3) @(negedge clk);
    check(in_ack == 1'b0, "R1 in_ack reset", {31'b0, in_ack}, '0);
    check(out_req == 1'b0, "R1 out_req reset", {31'b0, out_req}, '0);
    check(out_data == '0, "R1 out_data reset", out_data, '0);
    rst_ni = 1'b1;

    // First word, receiver idle
    @(negedge clk);
    in_data = wa;
    in_req  = 1'b1;
    @(negedge clk);
    check(in_ack == 1'b1, "R2 accept when empty", {31'b0, in_ack}, 1);
    check(out_req == 1'b0, "R5 request not yet raised", {31'b0, out_req}, 0);
    @(negedge clk);
    check(out_req == 1'b1, "R5 request raised", {31'b0, out_req}, 1);
    check(out_data == wa, "R5 word offered", out_data, wa);
    in_req  = 1'b0;
    in_data = 32'h1234_5678;
    @(negedge clk);
    check(in_ack == 1'b0, "R4 ack returns low", {31'b0, in_ack}, 0);

    // Second word waits on full buffer
    in_data = wb;
    in_req  = 1'b1;
    bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (in_ack) bad++;
    end
    check(bad == 0, "R3 full buffer ignores request", bad, 0);
    check(out_data == wa, "R5 word stable while offered", out_data, wa);

    out_ack = 1'b1;
    @(negedge clk);
    check(out_req == 1'b0, "R6 request drops after ack", {31'b0, out_req}, 0);
    bad = 0;
    repeat (5) begin
      @(negedge clk);
      if (in_ack) bad++;
    end
    check(bad == 0, "R9 still full while out ack high", bad, 0);
    out_ack = 1'b0;
    @(negedge clk);
    check(in_ack == 1'b0, "R9 not accepted on release edge", {31'b0, in_ack}, 0);
    check(out_req == 1'b0, "R7 no re-offer of old word", {31'b0, out_req}, 0);
    @(negedge clk);
    check(in_ack == 1'b1, "R9 accepted one edge after release", {31'b0, in_ack}, 1);
    @(negedge clk);
    check(out_req == 1'b1 && out_data == wb, "R8 second word offered", out_data, wb);
    in_req  = 1'b0;
    out_ack = 1'b1;
    @(negedge clk);
    out_ack = 1'b0;
    bad = 0;
    repeat (6) begin
      @(negedge clk);
      if (out_req || in_ack) bad++;
    end
    check(bad == 0, "R7 idle after delivery", bad, 0);

    // Streaming phase through the scoreboard
    rx_auto = 1'b1;
    for (int i = 0; i < N_STREAM; i++) begin
      send(32'(i) * 32'h9E37_79B9 ^ 32'h5A5A_0000);
      repeat (i % 3) @(negedge clk);
    end
    for (int k = 0; k < 200 && (exp_q.size() != 0 || out_ack); k++) @(negedge clk);
    check(delivered == N_STREAM, "R8 all words delivered", delivered, N_STREAM);
    check(exp_q.size() == 0, "R8 scoreboard empty", exp_q.size(), 0);

    done_flag = 1'b1;
    summary();
    $finish;
  end
endmodule